// File: doc/BRIEF.md
# Grouped Carry-Bypass Adder

This block is a purely combinational binary adder. It takes two `WIDTH`-bit operands and a carry-in and returns a `WIDTH`-bit sum and a carry-out.

The operand bits are cut into equal slices of `GRP` bits, and each slice is handled by its own small ripple chain. Alongside each chain sits a bypass path: when every bit of the slice would pass an incoming carry straight through, the slice's outgoing carry is taken directly from its incoming carry. In that case the carry does not wait for the ripple. The slices are linked in a line, so a carry can hop over any run of fully passing slices.

A parameter `BYPASS_EN` removes the bypass selectors. The block then degrades to an ordinary ripple adder with identical results.

Top module: `csk_adder`

## Requirements
- R1: For every pair of operands and both carry-in values, `{cout, sum}` equals `a + b + cin` taken as a `WIDTH+1`-bit unsigned value.
- R2: Per bit position, the pass condition is `a[i] ^ b[i]` and the create condition is `a[i] & b[i]`. Inside a slice, each sum bit is the pass condition XOR the carry entering that bit.
- R3: When all pass conditions of a slice are 1, the carry leaving that slice equals the carry entering it. For example, with `a = ~b`, `cout` equals `cin` and `sum` equals all ones when `cin` is 0, or all zeros when `cin` is 1.
- R4: When at least one bit of a slice does not pass, the carry leaving the slice is the last carry of that slice's ripple chain. For example, a carry created in the top bit of a slice (both operands 1 there) enters the next slice.
- R5: A slice containing a bit with its create condition set never takes the bypass.
- R6: With `BYPASS_EN = 0`, the outputs are identical to those with `BYPASS_EN = 1` for every input.
- R7: `cout` is the carry leaving the most significant slice.
- R8: `WIDTH` must be a whole multiple of `GRP`; this is enforced when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top slice |

## Verification
An 8-bit, two-slice build is swept over every operand pair with both carry-in values. This separates a broken bypass from a broken ripple, because the sweep includes every mix of passing and non-passing slices.

Operands of the form `a = ~b` make every slice bypass. These cases show whether the carry-in reaches the carry-out unchanged.

Operands with both bits set at the top of a slice show whether a created carry crosses the slice border.

A bypass-free copy is compared against the bypass build on every vector. Wider and odd-slice builds are tried with directed and pseudo-random operands.

// File: rtl/csk_pkg.sv
package csk_pkg;

  typedef enum logic {
    CARRY_FROM_CHAIN  = 1'b0,
    CARRY_FROM_BYPASS = 1'b1
  } carry_src_e;

  function automatic logic pick_carry(carry_src_e src, logic c_enter, logic c_chain);
    return (src == CARRY_FROM_BYPASS) ? c_enter : c_chain;
  endfunction

endpackage

// File: rtl/csk_bit_cond.sv
module csk_bit_cond #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] pass_v,
  output logic [WIDTH-1:0] make_v
);
  // R2: per-bit pass and create conditions
  assign pass_v = a ^ b;
  assign make_v = a & b;
endmodule

// File: rtl/csk_ripple_group.sv
module csk_ripple_group #(
  parameter int GRP = 4
) (
  input  logic [GRP-1:0] pass_v,
  input  logic [GRP-1:0] make_v,
  input  logic           c_enter,
  output logic [GRP-1:0] s,
  output logic           c_chain
);
  always_comb begin
    logic c;
    c = c_enter;
    for (int i = 0; i < GRP; i++) begin
      s[i] = pass_v[i] ^ c;
      c    = make_v[i] | (pass_v[i] & c);
    end
    c_chain = c;
  end
endmodule

// File: rtl/csk_bypass_sel.sv
module csk_bypass_sel
  import csk_pkg::*;
#(
  parameter int GRP       = 4,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic [GRP-1:0] pass_v,
  input  logic           c_enter,
  input  logic           c_chain,
  output logic           all_pass,
  output logic           c_leave
);
  assign all_pass = &pass_v;

  generate
    if (BYPASS_EN) begin : g_bypass
      carry_src_e src;
      assign src     = all_pass ? CARRY_FROM_BYPASS : CARRY_FROM_CHAIN;
      assign c_leave = pick_carry(src, c_enter, c_chain);
    end else begin : g_plain
      assign c_leave = pick_carry(CARRY_FROM_CHAIN, c_enter, c_chain);
    end
  endgenerate
endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
  parameter int WIDTH     = 32,
  parameter int GRP       = 4,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGRP = WIDTH / GRP;

  // R8: slice size must divide the width
  if ((WIDTH % GRP) != 0) begin : g_bad_cfg
    $error("csk_adder: WIDTH must be a multiple of GRP");
  end

  logic [WIDTH-1:0] pass_v;
  logic [WIDTH-1:0] make_v;

  csk_bit_cond #(.WIDTH(WIDTH)) u_cond (
    .a(a), .b(b), .pass_v(pass_v), .make_v(make_v)
  );

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    logic [GRP-1:0] p_w;
    logic [GRP-1:0] g_w;
    logic           c_enter_w;
    logic           c_chain_w;
    logic           all_pass_w;
    logic           c_leave_w;

    assign p_w = pass_v[gi*GRP +: GRP];
    assign g_w = make_v[gi*GRP +: GRP];

    if (gi == 0) begin : g_first
      assign c_enter_w = cin;
    end else begin : g_next
      assign c_enter_w = g_grp[gi-1].c_leave_w;
    end

    csk_ripple_group #(.GRP(GRP)) u_chain (
      .pass_v(p_w), .make_v(g_w), .c_enter(c_enter_w),
      .s(sum[gi*GRP +: GRP]), .c_chain(c_chain_w)
    );

    csk_bypass_sel #(.GRP(GRP), .BYPASS_EN(BYPASS_EN)) u_sel (
      .pass_v(p_w), .c_enter(c_enter_w), .c_chain(c_chain_w),
      .all_pass(all_pass_w), .c_leave(c_leave_w)
    );

    always_comb begin
      if (all_pass_w)
        a_r3_bypass_keeps_carry: assert (c_leave_w == c_enter_w)
          else $error("R3: fully passing slice %0d changed its carry", gi);
      if (!all_pass_w)
        a_r4_blocked_uses_chain: assert (c_leave_w == c_chain_w)
          else $error("R4: blocked slice %0d did not use chain carry", gi);
      if (|g_w)
        a_r5_create_blocks_bypass: assert (!all_pass_w)
          else $error("R5: slice %0d bypassed with a created carry", gi);
    end
  end

  assign cout = g_grp[NGRP-1].c_leave_w;

  always_comb begin
    a_r1_total_matches: assert ({cout, sum} ==
        ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("R1: adder result mismatch");
  end
endmodule

// File: tb/csk_adder_tb.sv
module csk_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W8 = 8;
  localparam int W32 = 32;
  localparam int W12 = 12;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [W8-1:0]  a8, b8;
  logic           c8;
  logic [W8-1:0]  s8, s8r;
  logic           co8, co8r;

  logic [W32-1:0] a32, b32;
  logic           c32;
  logic [W32-1:0] s32;
  logic           co32;

  logic [W12-1:0] a12, b12;
  logic           c12;
  logic [W12-1:0] s12;
  logic           co12;

  csk_adder #(.WIDTH(W8), .GRP(4), .BYPASS_EN(1'b1)) u_dut (
    .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8));
  csk_adder #(.WIDTH(W8), .GRP(4), .BYPASS_EN(1'b0)) u_dut_plain (
    .a(a8), .b(b8), .cin(c8), .sum(s8r), .cout(co8r));
  csk_adder #(.WIDTH(W32), .GRP(4), .BYPASS_EN(1'b1)) u_dut_wide (
    .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));
  csk_adder #(.WIDTH(W12), .GRP(3), .BYPASS_EN(1'b1)) u_dut_odd (
    .a(a12), .b(b12), .cin(c12), .sum(s12), .cout(co12));

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] ref_add(logic [63:0] x, logic [63:0] y, logic c);
    return x + y + {63'd0, c};
  endfunction

  task automatic run32(string req, logic [W32-1:0] x, logic [W32-1:0] y, logic c);
    a32 = x; b32 = y; c32 = c;
    #1;
    check(req, {31'd0, co32, s32}, ref_add({32'd0, x}, {32'd0, y}, c));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W32-1:0] ra, rb;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    a12 = '0; b12 = '0; c12 = 1'b0;
    #1;
    // R1: idle zero inputs give zero output
    check("R1 zero", {55'd0, co8, s8}, 64'd0);

    // R1 / R6: full sweep of the 8-bit build against arithmetic and plain copy
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int c = 0; c < 2; c++) begin
          a8 = x[7:0]; b8 = y[7:0]; c8 = c[0];
          #1;
          check("R1 sweep", {55'd0, co8, s8}, ref_add(64'(x), 64'(y), c[0]));
          check("R6 plain-equal", {55'd0, co8r, s8r}, {55'd0, co8, s8});
        end
      end
    end

    // R3: every slice fully passes
    run32("R3 allpass cin0", 32'h5A5A_A5A5, ~32'h5A5A_A5A5, 1'b0);
    check("R3 allpass cin0 cout", {63'd0, co32}, 64'd0);
    check("R3 allpass cin0 sum", {32'd0, s32}, 64'hFFFF_FFFF);
    run32("R3 allpass cin1", 32'h1234_5678, ~32'h1234_5678, 1'b1);
    check("R3 allpass cin1 cout", {63'd0, co32}, 64'd1);
    check("R3 allpass cin1 sum", {32'd0, s32}, 64'd0);

    // R4 / R5: carries created at the top bit of each slice
    run32("R4 top-bit create", 32'h8888_8888, 32'h8888_8888, 1'b0);
    run32("R5 create low then pass", 32'h0000_000F, 32'hFFFF_FFF1, 1'b0);
    run32("R4 mixed border", 32'h7FFF_FFF8, 32'h0000_0008, 1'b1);
    // R7: carry out of the top slice only
    run32("R7 top slice carry", 32'hF000_0000, 32'h1000_0000, 1'b0);
    check("R7 cout set", {63'd0, co32}, 64'd1);
    run32("R7 max", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);

    // R1: pseudo-random operands on the wide build
    ra = 32'h1357_9BDF; rb = 32'h2468_ACE0;
    for (int k = 0; k < 200; k++) begin
      ra = ra * 32'd1664525 + 32'd1013904223;
      rb = rb ^ (rb << 13); rb = rb ^ (rb >> 17); rb = rb ^ (rb << 5);
      run32("R1 random", ra, rb, ra[3]);
    end

    // R2 / R3: three-bit slices, twelve-bit width
    for (int x = 0; x < 4096; x += 37) begin
      for (int c = 0; c < 2; c++) begin
        a12 = x[11:0]; b12 = ~x[11:0]; c12 = c[0];
        #1;
        check("R3 odd allpass", {51'd0, co12, s12},
              ref_add(64'(x[11:0]), 64'(~x[11:0] & 12'hFFF), c[0]));
        b12 = 12'(x * 5 + 3);
        #1;
        check("R2 odd mixed", {51'd0, co12, s12},
              ref_add(64'(x[11:0]), 64'(b12), c[0]));
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule